// File: doc/BRIEF.md
# Five-Level Phase-Disposition PWM Gate Generator

This block drives the six power switches of a single-phase five-level inverter. A held reference sample is scaled by a modulation index. Its magnitude is compared against two triangular carriers of the same shape and frequency. The second carrier sits one carrier amplitude above the first, so together they cover the whole magnitude range. The sign of the reference selects the half-cycle and drives the two middle switches. Those switches therefore change state only when the reference crosses zero. The other four switches follow the carrier comparisons at the switching rate.

The selected level runs through a fixed switch-state table. For each level that can be built in more than one way, the table always picks the same switch state. A dead-time stage then delays every turn-on by a programmable number of clock cycles. The reference arrives on a valid/ready stream, and the block takes one sample per carrier period. `ref_ready_o` is high only in the cycle where the carrier is at its peak. A source that holds `ref_valid_i` low in that cycle is skipped without penalty: the block keeps the previous sample for another carrier period. A source that wants a sample taken must hold both the data and `ref_valid_i` until it sees ready.

The carrier half-period (P, in clock cycles), the modulation index and the dead time are plain control inputs. Dropping `en_i` or asserting reset parks the block with every gate off.

Top module: `pdpwm5_gate_gen`

## Requirements
- R1: The carrier count climbs 0,1,…,P and then falls P−1,…,1, giving a period of 2·P clock cycles. `peak_o` is high for exactly one cycle per period, in the cycle where the count equals P. A P of 0 behaves as P = 1.
- R2: `ref_ready_o` is high only while enabled and only in a peak cycle. A sample is captured when `ref_valid_i` and `ref_ready_o` are both high. Data offered without that handshake has no effect on the level output.
- R3: Let F = REF_W−1 (11 by default). Let X = m·2·P and let c be the carrier count. The level magnitude is 2 when X > (c+P)·2^F. Otherwise it is 1 when X > c·2^F. Otherwise it is 0. A tie resolves to the lower magnitude. The level is registered one cycle after the count it was compared against.
- R4: A negative held sample gives the mirrored negative level. A held sample of zero or above counts as the positive half-cycle.
- R5: `level_o` is a 3-bit two's-complement value limited to −2…+2.
- R6: Gate bit order is bit0 = A1, bit1 = A2, bit2 = A3, bit3 = B1, bit4 = B2, bit5 = B3. The settled gates for each level are:
  - +2: A2, B1, B3 on.
  - +1: A2, A3, B1 on.
  - 0 in the positive half-cycle: A1, A2, A3 on.
  - 0 in the negative half-cycle: B1, B2, B3 on.
  - −1: A1, B2, B3 on.
  - −2: A1, A3, B2 on.
- R7: Gate bit1 is on only in the positive half-cycle and gate bit4 only in the negative one. The two are never on together. Neither changes while the sign of the held sample is unchanged.
- R8: A gate turns off one cycle after its target drops. A gate whose target rises turns on `dead_i` cycles after that. When one level change turns one gate off and another on, the gap between the two is exactly `dead_i` cycles. With `dead_i` ≥ 1, no gate turns on in the same cycle as a gate of its own leg (bits 0–2 or bits 3–5) turns off.
- R9: In reset, and in the cycle after `en_i` is sampled low, every gate is off, and the level, ready and peak outputs are 0. After enable returns, the carrier restarts from 0, so the first peak arrives P cycles later.
- R10: The magnitude used in R3 is m = floor(|ref|·mi / 2^MI_W). Here mi is an unsigned fraction with MI_W fraction bits (8 by default).
- R11: The settled gate count never exceeds three, and during a dead-time gap it is lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low parks the block |
| ref_valid_i | input | 1 | Reference sample valid |
| ref_ready_o | output | 1 | Sample accepted this cycle if valid |
| ref_data_i | input | REF_W | Signed reference sample, full scale ±2^F |
| mod_index_i | input | MI_W | Modulation index, unsigned fraction |
| half_period_i | input | PER_W | Carrier half-period P in cycles |
| dead_i | input | DT_W | Dead time in cycles |
| gate_o | output | 6 | Gate drives, order per R6 |
| level_o | output | 3 | Selected output level, two's complement |
| peak_o | output | 1 | Carrier peak strobe |

## Verification
The bench targets samples that land exactly on a carrier threshold. A design that compares with ≥ instead of > shifts one cycle per period into the higher level. It drives the most negative sample, which a naive absolute value would wrap to a negative magnitude. It drives a zero and a tiny negative reference, where a wrong half-cycle choice puts the load short on the wrong side. It steps the sign across zero and measures the gap between the middle-switch turn-off and turn-on, which a broken delay would shorten or lose. It also withholds the handshake while changing the data, and checks that the level pattern does not move.

// File: rtl/pdpwm5_pkg.sv
package pdpwm5_pkg;

  localparam int NUM_SW = 6;
  localparam int SW_A1  = 0;
  localparam int SW_A2  = 1;
  localparam int SW_A3  = 2;
  localparam int SW_B1  = 3;
  localparam int SW_B2  = 4;
  localparam int SW_B3  = 5;

  typedef logic signed [2:0] lvl_t;

  // Fixed choice among redundant states: first option for +-1, and
  // the zero state keeps the middle switch of the current half-cycle.
  function automatic logic [NUM_SW-1:0] lvl_to_gates(input lvl_t lvl, input logic pos);
    logic [NUM_SW-1:0] g;
    g = '0;
    case (lvl)
      3'sd2: begin
        g[SW_A2] = 1'b1; g[SW_B1] = 1'b1; g[SW_B3] = 1'b1;
      end
      3'sd1: begin
        g[SW_A2] = 1'b1; g[SW_A3] = 1'b1; g[SW_B1] = 1'b1;
      end
      -3'sd1: begin
        g[SW_A1] = 1'b1; g[SW_B2] = 1'b1; g[SW_B3] = 1'b1;
      end
      -3'sd2: begin
        g[SW_A1] = 1'b1; g[SW_A3] = 1'b1; g[SW_B2] = 1'b1;
      end
      default: begin
        if (pos) begin
          g[SW_A1] = 1'b1; g[SW_A2] = 1'b1; g[SW_A3] = 1'b1;
        end else begin
          g[SW_B1] = 1'b1; g[SW_B2] = 1'b1; g[SW_B3] = 1'b1;
        end
      end
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pdpwm5_carrier.sv
module pdpwm5_carrier #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] half_period_i,
  output logic [PER_W-1:0] eff_p_o,
  output logic [PER_W-1:0] cnt_o,
  output logic             peak_o
);

  logic [PER_W-1:0] cnt_q;
  logic             up_q;

  assign eff_p_o = (half_period_i == '0) ? PER_W'(1) : half_period_i;
  assign cnt_o   = cnt_q;
  assign peak_o  = en_i && (cnt_q == eff_p_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!en_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if (cnt_q >= eff_p_o) begin
        cnt_q <= cnt_q - 1'b1;
        up_q  <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if ((cnt_q + 1'b1) == eff_p_o) up_q <= 1'b0;
      end
    end else begin
      if (cnt_q <= PER_W'(1)) begin
        cnt_q <= '0;
        up_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R1: the peak strobe is one cycle wide while the period is steady
  p_peak_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && peak_o) ##1 (en_i && $stable(half_period_i)) |-> !peak_o)
    else $error("peak strobe longer than one cycle");

  // R9: disabling returns the carrier to its start
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0) && !peak_o)
    else $error("carrier not parked while disabled");

endmodule

// File: rtl/pdpwm5_level.sv
module pdpwm5_level
  import pdpwm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int MI_W  = 8,
  parameter int PER_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    ref_valid_i,
  output logic                    ref_ready_o,
  input  logic signed [REF_W-1:0] ref_data_i,
  input  logic [MI_W-1:0]         mod_index_i,
  input  logic [PER_W-1:0]        eff_p_i,
  input  logic [PER_W-1:0]        cnt_i,
  input  logic                    peak_i,
  output lvl_t                    lvl_o,
  output logic                    pos_o
);

  localparam int F      = REF_W - 1;
  localparam int PROD_W = REF_W + MI_W;
  localparam int X_W    = REF_W + PER_W + 1;

  logic signed [REF_W-1:0] held_ref;
  logic [REF_W-1:0]        neg_ref;
  logic [REF_W-1:0]        mag;
  logic [PROD_W-1:0]       prod;
  logic [REF_W-1:0]        m_scaled;
  logic [X_W-1:0]          x_val;
  logic [X_W-1:0]          lo_th;
  logic [X_W-1:0]          hi_th;
  logic [1:0]              mag_lvl;
  logic                    neg_half;
  lvl_t                    lvl_next;
  lvl_t                    lvl_q;
  logic                    pos_q;
  logic                    accept;

  assign ref_ready_o = en_i && peak_i;
  assign accept      = ref_valid_i && ref_ready_o;

  assign neg_half = held_ref[REF_W-1];
  assign neg_ref  = $unsigned(-held_ref);
  assign mag      = neg_half ? neg_ref : $unsigned(held_ref);
  assign prod     = PROD_W'(mag) * PROD_W'(mod_index_i);
  assign m_scaled = prod[PROD_W-1:MI_W];
  assign x_val    = X_W'(m_scaled) * X_W'({eff_p_i, 1'b0});
  assign lo_th    = X_W'(cnt_i) << F;
  assign hi_th    = (X_W'(cnt_i) + X_W'(eff_p_i)) << F;

  always_comb begin
    if (x_val > hi_th)      mag_lvl = 2'd2;
    else if (x_val > lo_th) mag_lvl = 2'd1;
    else                    mag_lvl = 2'd0;
    lvl_next = neg_half ? -$signed({1'b0, mag_lvl}) : $signed({1'b0, mag_lvl});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_ref <= '0;
      lvl_q    <= '0;
      pos_q    <= 1'b1;
    end else if (!en_i) begin
      held_ref <= '0;
      lvl_q    <= '0;
      pos_q    <= 1'b1;
    end else begin
      if (accept) held_ref <= ref_data_i;
      lvl_q <= lvl_next;
      pos_q <= !neg_half;
    end
  end

  assign lvl_o = lvl_q;
  assign pos_o = pos_q;

  // R2: without a handshake the held sample does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !accept) ##1 en_i |-> $stable(held_ref))
    else $error("held reference changed without handshake");

  // R5: level code stays within -2..+2
  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q <= 3'sd2) && (lvl_q >= -3'sd2))
    else $error("level code out of range");

  // R4: positive half-cycle never carries a negative level
  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q |-> (lvl_q >= 3'sd0))
    else $error("level sign disagrees with half-cycle");

endmodule

// File: rtl/pdpwm5_deadband.sv
module pdpwm5_deadband #(
  parameter int N    = 6,
  parameter int DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [N-1:0]    target_i,
  input  logic [DT_W-1:0] dead_i,
  output logic [N-1:0]    gate_o
);

  for (genvar i = 0; i < N; i++) begin : g_sw
    logic [DT_W-1:0] wait_q;
    logic            on_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wait_q <= '0;
        on_q   <= 1'b0;
      end else if (!en_i || !target_i[i]) begin
        wait_q <= '0;
        on_q   <= 1'b0;
      end else if (!on_q) begin
        if (wait_q >= dead_i) on_q <= 1'b1;
        else                  wait_q <= wait_q + 1'b1;
      end
    end

    assign gate_o[i] = on_q;

    // R8: turn-off follows the target within one cycle
    p_fall_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !target_i[i] |=> !gate_o[i])
      else $error("gate stayed on after target dropped");
  end

endmodule

// File: rtl/pdpwm5_gate_gen.sv
module pdpwm5_gate_gen
  import pdpwm5_pkg::*;
#(
  parameter int REF_W = 12,
  parameter int MI_W  = 8,
  parameter int PER_W = 12,
  parameter int DT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    ref_valid_i,
  output logic                    ref_ready_o,
  input  logic signed [REF_W-1:0] ref_data_i,
  input  logic [MI_W-1:0]         mod_index_i,
  input  logic [PER_W-1:0]        half_period_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [NUM_SW-1:0]       gate_o,
  output logic [2:0]              level_o,
  output logic                    peak_o
);

  logic [PER_W-1:0]  eff_p;
  logic [PER_W-1:0]  cnt;
  logic              peak;
  lvl_t              lvl;
  logic              pos;
  logic [NUM_SW-1:0] target;

  pdpwm5_carrier #(.PER_W(PER_W)) u_carrier (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en_i),
    .half_period_i (half_period_i),
    .eff_p_o       (eff_p),
    .cnt_o         (cnt),
    .peak_o        (peak)
  );

  pdpwm5_level #(.REF_W(REF_W), .MI_W(MI_W), .PER_W(PER_W)) u_level (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en_i),
    .ref_valid_i (ref_valid_i),
    .ref_ready_o (ref_ready_o),
    .ref_data_i  (ref_data_i),
    .mod_index_i (mod_index_i),
    .eff_p_i     (eff_p),
    .cnt_i       (cnt),
    .peak_i      (peak),
    .lvl_o       (lvl),
    .pos_o       (pos)
  );

  assign target = lvl_to_gates(lvl, pos);

  pdpwm5_deadband #(.N(NUM_SW), .DT_W(DT_W)) u_dead (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .target_i (target),
    .dead_i   (dead_i),
    .gate_o   (gate_o)
  );

  assign level_o = lvl;
  assign peak_o  = peak;

  // R7: the two middle switches are never on together
  p_mid_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[SW_A2] && gate_o[SW_B2]))
    else $error("both middle switches on");

  // R11: never more than three gates on
  p_on_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gate_o) <= 3)
    else $error("too many gates on");

  // R8: leg A has no turn-on in a cycle where one of its gates turns off
  p_leg_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dead_i != '0) && ((gate_o[2:0] & ~$past(gate_o[2:0])) != 3'b000))
      |-> ((~gate_o[2:0] & $past(gate_o[2:0])) == 3'b000))
    else $error("leg A overlap");

  // R8: the same rule for leg B
  p_leg_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dead_i != '0) && ((gate_o[5:3] & ~$past(gate_o[5:3])) != 3'b000))
      |-> ((~gate_o[5:3] & $past(gate_o[5:3])) == 3'b000))
    else $error("leg B overlap");

  // R9: gates are off in the cycle after disable
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (gate_o == '0) && (level_o == 3'b000))
    else $error("outputs active while disabled");

endmodule

// File: tb/tb_pdpwm5_gate_gen.sv
module tb_pdpwm5_gate_gen;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              ref_valid = 1'b0;
  logic              ref_ready;
  logic signed [11:0] ref_data = '0;
  logic [7:0]        mod_index = '0;
  logic [11:0]       half_period = 12'd8;
  logic [5:0]        dead = '0;
  logic [5:0]        gate;
  logic [2:0]        level;
  logic              peak;

  pdpwm5_gate_gen dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (en),
    .ref_valid_i   (ref_valid),
    .ref_ready_o   (ref_ready),
    .ref_data_i    (ref_data),
    .mod_index_i   (mod_index),
    .half_period_i (half_period),
    .dead_i        (dead),
    .gate_o        (gate),
    .level_o       (level),
    .peak_o        (peak)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  int cyc = 0;
  int run = 0;
  logic [2:0] prev_l = '0;
  logic [5:0] prev_g = '0;
  int overlap_ev = 0;
  int ready_bad  = 0;
  int s2_tog     = 0;
  int last_peak  = -1;
  int last_gap   = -1;
  int a2_fall    = -1;
  int b2_rise    = -1;

  // stimulus/expected table: reference, index, half-period, dead time, expected sign
  localparam int NV = 8;
  localparam int V_REF [NV] = '{1800, -1800, 1024, -2048, 0, -40, 600, 2047};
  localparam int V_MI  [NV] = '{179, 179, 128, 255, 179, 179, 255, 255};
  localparam int V_P   [NV] = '{8, 8, 8, 8, 8, 8, 5, 3};
  localparam int V_D   [NV] = '{2, 2, 0, 3, 1, 2, 1, 0};
  localparam int V_POS [NV] = '{1, 0, 1, 0, 1, 0, 1, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [5:0] rise;
    logic [5:0] fall;
    @(negedge clk);
    cyc++;
    rise = gate & ~prev_g;
    fall = ~gate & prev_g;
    if (level == prev_l) run++;
    else run = 1;
    prev_l = level;
    if (dead != 0) begin
      if ((rise[2:0] != 0 && fall[2:0] != 0) || (rise[5:3] != 0 && fall[5:3] != 0))
        overlap_ev++;
    end
    if (ref_ready && !peak) ready_bad++;
    if (gate[1] != prev_g[1]) s2_tog++;
    if (fall[1]) a2_fall = cyc;
    if (rise[4]) b2_rise = cyc;
    if (peak) begin
      if (last_peak >= 0) last_gap = cyc - last_peak;
      last_peak = cyc;
    end
    prev_g = gate;
  endtask

  function automatic logic [5:0] exp_gates(input int lv, input bit pos);
    logic a1, a2, a3, b1, b2, b3;
    {a1, a2, a3, b1, b2, b3} = 6'b000000;
    if (lv == 2)       {a1, a2, a3, b1, b2, b3} = 6'b010101;
    else if (lv == 1)  {a1, a2, a3, b1, b2, b3} = 6'b011100;
    else if (lv == -1) {a1, a2, a3, b1, b2, b3} = 6'b100011;
    else if (lv == -2) {a1, a2, a3, b1, b2, b3} = 6'b101010;
    else if (pos)      {a1, a2, a3, b1, b2, b3} = 6'b111000;
    else               {a1, a2, a3, b1, b2, b3} = 6'b000111;
    return {b3, b2, b1, a3, a2, a1};
  endfunction

  // counts per carrier period from R3/R10 (F = 11, 8 fraction bits)
  task automatic exp_counts(input int r, input int mi, input int p,
                            output int n2, output int n1, output int n0);
    int pe;
    int a;
    longint m;
    longint x;
    pe = (p == 0) ? 1 : p;
    a  = (r < 0) ? -r : r;
    m  = (longint'(a) * mi) >>> 8;
    x  = m * 2 * pe;
    n2 = 0; n1 = 0; n0 = 0;
    for (int k = 0; k < 2 * pe; k++) begin
      int c;
      c = (k <= pe) ? k : 2 * pe - k;
      if (x > (longint'(c + pe) <<< 11)) n2++;
      else if (x > (longint'(c) <<< 11)) n1++;
      else n0++;
    end
  endtask

  // measures one carrier period and checks it against r
  task automatic window(input int r, input int mi, input int p, input bit pos, input string req);
    int pe, c2, c1, c0, bad_sign, bad_map, e2, e1, e0;
    pe = (p == 0) ? 1 : p;
    c2 = 0; c1 = 0; c0 = 0; bad_sign = 0; bad_map = 0;
    s2_tog = 0;
    for (int k = 0; k < 2 * pe; k++) begin
      int lv;
      tick();
      lv = int'($signed(level));
      if (lv == 2 || lv == -2) c2++;
      else if (lv == 1 || lv == -1) c1++;
      else c0++;
      if ((pos && lv < 0) || (!pos && lv > 0)) bad_sign++;
      if (run >= int'(dead) + 2 && gate != exp_gates(lv, pos)) bad_map++;
    end
    exp_counts(r, mi, p, e2, e1, e0);
    chk(c2 == e2, req, c2, e2, "R3 cycles at magnitude 2");
    chk(c1 == e1, req, c1, e1, "R3/R10 cycles at magnitude 1");
    chk(c0 == e0, req, c0, e0, "R3 cycles at level 0");
    chk(bad_sign == 0, "R4", bad_sign, 0, "level sign mismatches");
    chk(bad_map == 0, "R6", bad_map, 0, "settled gate mismatches");
    chk(s2_tog == 0, "R7", s2_tog, 0, "middle switch toggles in one half-cycle");
    chk(last_gap == 2 * pe, "R1", last_gap, 2 * pe, "peak spacing");
  endtask

  task automatic apply(input int r, input int mi, input int p, input int d);
    ref_data    = 12'(r);
    mod_index   = 8'(mi);
    half_period = 12'(p);
    dead        = 6'(d);
    ref_valid   = 1'b1;
    for (int k = 0; k < 6 * ((p == 0) ? 1 : p) + d + 10; k++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: actual 0 expected 1 completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int n;
    // reset state (R9)
    en = 1'b1;
    ref_valid = 1'b1;
    ref_data = 12'sd500;
    mod_index = 8'd200;
    for (int k = 0; k < 4; k++) tick();
    chk(gate == 6'b0, "R9", int'(gate), 0, "gates in reset");
    chk(level == 3'b0, "R9", int'(level), 0, "level in reset");
    chk(!ref_ready && !peak, "R9", int'({ref_ready, peak}), 0, "ready/peak in reset");
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      apply(V_REF[v], V_MI[v], V_P[v], V_D[v]);
      window(V_REF[v], V_MI[v], V_P[v], V_POS[v] != 0, $sformatf("vector %0d", v));
    end

    // R2: data without handshake is ignored
    apply(1800, 179, 8, 2);
    ref_valid = 1'b0;
    ref_data  = -12'sd1800;
    for (int k = 0; k < 64; k++) tick();
    window(1800, 179, 8, 1'b1, "R2 held sample");
    chk(ready_bad == 0, "R2", ready_bad, 0, "ready outside peak");

    // R7/R8: sign step, exact gap between middle switches
    apply(1500, 200, 8, 3);
    a2_fall = -1;
    b2_rise = -1;
    ref_data = -12'sd1500;
    for (int k = 0; k < 64; k++) tick();
    chk(a2_fall >= 0 && b2_rise - a2_fall == 3, "R8", b2_rise - a2_fall, 3, "dead gap at sign change");
    chk(gate[4] && !gate[1], "R7", int'({gate[4], gate[1]}), 2, "middle switches after sign change");

    // R1: zero half-period acts as one
    apply(1000, 128, 0, 0);
    chk(last_gap == 2, "R1", last_gap, 2, "peak spacing with P=0");

    // R9: disable and restart
    apply(1500, 200, 8, 2);
    en = 1'b0;
    tick();
    chk(gate == 6'b0 && level == 3'b0, "R9", int'(gate), 0, "gates after disable");
    chk(!peak && !ref_ready, "R9", int'({ref_ready, peak}), 0, "strobes after disable");
    for (int k = 0; k < 3; k++) tick();
    en = 1'b1;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      tick();
      n++;
      if (peak) break;
    end
    chk(n == 8, "R9", n, 8, "cycles to first peak after enable");

    chk(overlap_ev == 0, "R8", overlap_ev, 0, "same-leg on/off coincidences");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule